// File: doc/BRIEF.md
# Scanout Mode Geometry Validator

This block turns the raw values held in a display adapter's mode registers into a checked description of the framebuffer that scanout should read. It takes an enable bit, a colour depth, the visible width and height, a virtual line width, horizontal and vertical pan offsets and a byte-order flag. From these it derives the pixel format, bytes per pixel, line stride, start offset and frame size. It accepts the mode only when the whole frame fits in the video memory, whose size in bytes is a parameter.

Every clock edge it registers a validity flag for the current inputs. When a usable mode differs in any field from the last mode it accepted, it takes the new description and raises a change pulse for one cycle. A scanout engine can use that pulse to rebuild its surface. While the registers describe an unusable mode, the last accepted description stays on the outputs. A host can therefore pass through illegal intermediate values while it reprograms the registers without disturbing scanout.

Top module: `scanout_mode_check`

## Requirements
- R1: While `modeEnable` is 0, `modeValid` is 0 one cycle later, whatever the other inputs are.
- R2: A `colorDepth` other than 16 or 32 makes the mode invalid.
- R3: Depth 16 gives 2 bytes per pixel and format code 1. Depth 32 gives 4 bytes per pixel, with format code 2 when `bigEndian` is 0 and format code 3 when it is 1. Code 0 means no mode has been accepted.
- R4: The line stride is the larger of `virtWidth` and `visWidth`, multiplied by bytes per pixel.
- R5: The frame size is stride times height. The start offset is `panX` times bytes per pixel plus `panY` times stride. Both are held without truncation in 37 bits.
- R6: A width or height below 64 makes the mode invalid. Exactly 64 is accepted.
- R7: The mode is invalid when offset plus size exceeds `MEM_BYTES`. A frame that ends exactly at `MEM_BYTES` is accepted.
- R8: When the inputs at a clock edge form a valid mode whose tuple (format, bytes per pixel, width, height, stride, offset, size) differs from the held tuple, the outputs take the new tuple at that edge and `modeChanged` is 1 for that one cycle.
- R9: A valid mode equal to the held tuple produces no change pulse.
- R10: While the mode is invalid, the held tuple does not change and `modeChanged` stays 0.
- R11: After reset, `modeValid` and `modeChanged` are 0 and every tuple output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeEnable | input | 1 | Display enable bit from the enable register |
| colorDepth | input | 16 | Bits per pixel |
| visWidth | input | 16 | Visible width in pixels |
| visHeight | input | 16 | Visible height in lines |
| virtWidth | input | 16 | Virtual line width in pixels |
| panX | input | 16 | Horizontal pan in pixels |
| panY | input | 16 | Vertical pan in lines |
| bigEndian | input | 1 | Byte order of 32-bit pixels |
| modeValid | output | 1 | Current inputs form a usable mode |
| modeChanged | output | 1 | One-cycle pulse when a new tuple is taken |
| pixFmt | output | 2 | Held format code |
| bytesPerPix | output | 3 | Held bytes per pixel |
| actWidth | output | 16 | Held width |
| actHeight | output | 16 | Held height |
| lineStride | output | 19 | Held stride in bytes |
| startOffset | output | 37 | Held start offset in bytes |
| frameSize | output | 37 | Held frame size in bytes |

## Verification
The change detector and the memory-fit rejection act in the same cycle. The bench makes them collide by programming geometry that differs from the held tuple but overruns memory. It does this once at the exact memory boundary plus one line of pan, and once with a grossly oversized frame. In both cases it expects no pulse and an unchanged tuple. A second collision pairs the pulse with a format-only change: flipping the byte-order flag alone must still fire the pulse even though every geometric field stays the same.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int DIM_W    = 16;
  localparam int BPP_W    = 3;
  localparam int STRIDE_W = DIM_W + BPP_W;
  localparam int ADDR_W   = 2 * DIM_W + 5;
  localparam int MIN_DIM  = 64;

  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    pix_fmt_e              fmt;
    logic [BPP_W-1:0]      bpp;
    logic [DIM_W-1:0]      width;
    logic [DIM_W-1:0]      height;
    logic [STRIDE_W-1:0]   stride;
    logic [ADDR_W-1:0]     offset;
    logic [ADDR_W-1:0]     size;
  } mode_tuple_t;

  typedef struct packed {
    logic load;
  } smc_strobe_t;
endpackage

// File: rtl/smc_dp.sv
module smc_dp
  import smc_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd16777216
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIM_W-1:0]  colorDepth,
  input  logic [DIM_W-1:0]  visWidth,
  input  logic [DIM_W-1:0]  visHeight,
  input  logic [DIM_W-1:0]  virtWidth,
  input  logic [DIM_W-1:0]  panX,
  input  logic [DIM_W-1:0]  panY,
  input  logic              bigEndian,
  input  smc_strobe_t       strobe,
  output logic              fits,
  output logic              differs,
  output mode_tuple_t       heldTuple
);
  logic [BPP_W-1:0]    bppC;
  pix_fmt_e            fmtC;
  logic [DIM_W-1:0]    effWidth;
  logic [STRIDE_W-1:0] strideC;
  logic [ADDR_W-1:0]   sizeC;
  logic [ADDR_W-1:0]   offsetC;
  logic [ADDR_W-1:0]   endC;
  mode_tuple_t         candTuple;

  // bytes per pixel and format; depths other than 16 are treated as 32
  // here, the controller rejects unsupported depths
  always_comb begin
    if (colorDepth == DIM_W'(16)) begin
      bppC = BPP_W'(2);
      fmtC = FMT_RGB565;
    end else begin
      bppC = BPP_W'(4);
      fmtC = bigEndian ? FMT_XRGB_BE : FMT_XRGB_LE;
    end
  end

  always_comb begin
    effWidth = (virtWidth < visWidth) ? visWidth : virtWidth;
    strideC  = STRIDE_W'(effWidth) * STRIDE_W'(bppC);
    sizeC    = ADDR_W'(strideC) * ADDR_W'(visHeight);
    offsetC  = ADDR_W'(panX) * ADDR_W'(bppC)
             + ADDR_W'(panY) * ADDR_W'(strideC);
    endC     = offsetC + sizeC;
    fits     = 64'(endC) <= MEM_BYTES;
  end

  always_comb begin
    candTuple.fmt    = fmtC;
    candTuple.bpp    = bppC;
    candTuple.width  = visWidth;
    candTuple.height = visHeight;
    candTuple.stride = strideC;
    candTuple.offset = offsetC;
    candTuple.size   = sizeC;
    differs          = candTuple != heldTuple;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldTuple <= '0;
    end else if (strobe.load) begin
      heldTuple <= candTuple;
    end
  end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeEnable,
  input  logic [DIM_W-1:0] colorDepth,
  input  logic [DIM_W-1:0] visWidth,
  input  logic [DIM_W-1:0] visHeight,
  input  logic             fits,
  input  logic             differs,
  output smc_strobe_t      strobe,
  output logic             modeValid,
  output logic             modeChanged
);
  logic depthOk;
  logic dimsOk;
  logic usable;

  always_comb begin
    depthOk     = (colorDepth == DIM_W'(16)) || (colorDepth == DIM_W'(32));
    dimsOk      = (visWidth >= DIM_W'(MIN_DIM)) && (visHeight >= DIM_W'(MIN_DIM));
    usable      = modeEnable && depthOk && dimsOk && fits;
    strobe.load = usable && differs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeValid   <= 1'b0;
      modeChanged <= 1'b0;
    end else begin
      modeValid   <= usable;
      modeChanged <= strobe.load;
    end
  end
endmodule

// File: rtl/scanout_mode_check.sv
module scanout_mode_check
  import smc_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd16777216
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeEnable,
  input  logic [DIM_W-1:0]    colorDepth,
  input  logic [DIM_W-1:0]    visWidth,
  input  logic [DIM_W-1:0]    visHeight,
  input  logic [DIM_W-1:0]    virtWidth,
  input  logic [DIM_W-1:0]    panX,
  input  logic [DIM_W-1:0]    panY,
  input  logic                bigEndian,
  output logic                modeValid,
  output logic                modeChanged,
  output logic [1:0]          pixFmt,
  output logic [BPP_W-1:0]    bytesPerPix,
  output logic [DIM_W-1:0]    actWidth,
  output logic [DIM_W-1:0]    actHeight,
  output logic [STRIDE_W-1:0] lineStride,
  output logic [ADDR_W-1:0]   startOffset,
  output logic [ADDR_W-1:0]   frameSize
);
  smc_strobe_t strobe;
  logic        fits;
  logic        differs;
  mode_tuple_t heldTuple;

  smc_dp #(.MEM_BYTES(MEM_BYTES)) dp (
    .clk(clk), .rstN(rstN), .colorDepth(colorDepth), .visWidth(visWidth),
    .visHeight(visHeight), .virtWidth(virtWidth), .panX(panX), .panY(panY),
    .bigEndian(bigEndian), .strobe(strobe), .fits(fits), .differs(differs),
    .heldTuple(heldTuple)
  );

  smc_ctrl ctrl (
    .clk(clk), .rstN(rstN), .modeEnable(modeEnable), .colorDepth(colorDepth),
    .visWidth(visWidth), .visHeight(visHeight), .fits(fits), .differs(differs),
    .strobe(strobe), .modeValid(modeValid), .modeChanged(modeChanged)
  );

  assign pixFmt      = heldTuple.fmt;
  assign bytesPerPix = heldTuple.bpp;
  assign actWidth    = heldTuple.width;
  assign actHeight   = heldTuple.height;
  assign lineStride  = heldTuple.stride;
  assign startOffset = heldTuple.offset;
  assign frameSize   = heldTuple.size;
endmodule

// File: rtl/smc_checker.sv
module smc_checker
  import smc_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd16777216
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeValid,
  input logic                modeChanged,
  input logic [1:0]          pixFmt,
  input logic [BPP_W-1:0]    bytesPerPix,
  input logic [DIM_W-1:0]    actWidth,
  input logic [DIM_W-1:0]    actHeight,
  input logic [STRIDE_W-1:0] lineStride,
  input logic [ADDR_W-1:0]   startOffset,
  input logic [ADDR_W-1:0]   frameSize
);
  logic [2+BPP_W+2*DIM_W+STRIDE_W+2*ADDR_W-1:0] snap;
  assign snap = {pixFmt, bytesPerPix, actWidth, actHeight, lineStride, startOffset, frameSize};

  // R8
  pulse_new_tuple_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> (snap != $past(snap)));
  // R9
  tuple_move_pulses_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snap != $past(snap)) |-> modeChanged);
  // R10
  invalid_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeValid |-> ($stable(snap) && !modeChanged));
  // R3
  bpp_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> ((bytesPerPix == 3'd2 && pixFmt == 2'd1) ||
                     (bytesPerPix == 3'd4 && pixFmt >= 2'd2)));
  // R6
  min_dims_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> (actWidth >= DIM_W'(MIN_DIM) && actHeight >= DIM_W'(MIN_DIM)));
  // R7
  fits_memory_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChanged |-> ((64'(startOffset) + 64'(frameSize)) <= MEM_BYTES));
endmodule

bind scanout_mode_check smc_checker #(.MEM_BYTES(MEM_BYTES)) chk (
  .clk(clk), .rstN(rstN), .modeValid(modeValid), .modeChanged(modeChanged),
  .pixFmt(pixFmt), .bytesPerPix(bytesPerPix), .actWidth(actWidth),
  .actHeight(actHeight), .lineStride(lineStride), .startOffset(startOffset),
  .frameSize(frameSize)
);

// File: tb/scanout_mode_check_test.sv
module scanout_mode_check_test;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned MEM = 64'd16777216;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeEnable = 1'b0;
  logic [15:0] colorDepth = '0, visWidth = '0, visHeight = '0;
  logic [15:0] virtWidth = '0, panX = '0, panY = '0;
  logic        bigEndian = 1'b0;
  logic        modeValid, modeChanged;
  logic [1:0]  pixFmt;
  logic [2:0]  bytesPerPix;
  logic [15:0] actWidth, actHeight;
  logic [18:0] lineStride;
  logic [36:0] startOffset, frameSize;

  int testsRun = 0;
  int testsFailed = 0;
  bit driverDone = 1'b0;

  typedef struct {
    string   tag;
    bit      valid;
    bit      changed;
    longint  fmt, bpp, w, h, stride, offset, size;
  } exp_t;

  exp_t expQ[$];
  exp_t held;

  scanout_mode_check #(.MEM_BYTES(MEM)) uut (
    .clk(clk), .rstN(rstN), .modeEnable(modeEnable), .colorDepth(colorDepth),
    .visWidth(visWidth), .visHeight(visHeight), .virtWidth(virtWidth),
    .panX(panX), .panY(panY), .bigEndian(bigEndian), .modeValid(modeValid),
    .modeChanged(modeChanged), .pixFmt(pixFmt), .bytesPerPix(bytesPerPix),
    .actWidth(actWidth), .actHeight(actHeight), .lineStride(lineStride),
    .startOffset(startOffset), .frameSize(frameSize)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input bit en, input int dep, input int w, input int h,
                       input int vw, input int x, input int y, input bit be,
                       input string tag);
    exp_t e;
    longint effW;
    bit ok;
    @(negedge clk);
    modeEnable = en; colorDepth = 16'(dep); visWidth = 16'(w); visHeight = 16'(h);
    virtWidth = 16'(vw); panX = 16'(x); panY = 16'(y); bigEndian = be;
    e = held;
    e.tag = tag;
    e.bpp = (dep == 16) ? 2 : 4;
    e.fmt = (dep == 16) ? 1 : (be ? 3 : 2);
    effW = (vw < w) ? w : vw;
    e.w = w; e.h = h;
    e.stride = effW * e.bpp;
    e.size = e.stride * h;
    e.offset = x * e.bpp + y * e.stride;
    ok = en && (dep == 16 || dep == 32) && w >= 64 && h >= 64 &&
         (e.offset + e.size) <= longint'(MEM);
    e.valid = ok;
    e.changed = ok && (e.fmt != held.fmt || e.bpp != held.bpp || e.w != held.w ||
                e.h != held.h || e.stride != held.stride ||
                e.offset != held.offset || e.size != held.size);
    if (e.changed) held = e;
    else begin
      e.fmt = held.fmt; e.bpp = held.bpp; e.w = held.w; e.h = held.h;
      e.stride = held.stride; e.offset = held.offset; e.size = held.size;
    end
    expQ.push_back(e);
  endtask

  // monitor: pops one expected item per clock edge after the driver pushes it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        testsRun++;
        if (modeValid !== e.valid || modeChanged !== e.changed ||
            longint'(pixFmt) != e.fmt || longint'(bytesPerPix) != e.bpp ||
            longint'(actWidth) != e.w || longint'(actHeight) != e.h ||
            longint'(lineStride) != e.stride || longint'(startOffset) != e.offset ||
            longint'(frameSize) != e.size) begin
          testsFailed++;
          $display("FAIL %s: got v=%0b c=%0b fmt=%0d bpp=%0d %0dx%0d st=%0d off=%0d sz=%0d, exp v=%0b c=%0b fmt=%0d bpp=%0d %0dx%0d st=%0d off=%0d sz=%0d",
            e.tag, modeValid, modeChanged, pixFmt, bytesPerPix, actWidth, actHeight,
            lineStride, startOffset, frameSize, e.valid, e.changed, e.fmt, e.bpp,
            e.w, e.h, e.stride, e.offset, e.size);
        end
      end
    end
  end

  initial begin
    held = '{tag: "", valid: 0, changed: 0, fmt: 0, bpp: 0, w: 0, h: 0,
             stride: 0, offset: 0, size: 0};
    repeat (3) @(posedge clk);
    #1;
    testsRun++;
    if (modeValid !== 1'b0 || modeChanged !== 1'b0 || pixFmt !== 2'd0 ||
        bytesPerPix !== 3'd0 || actWidth !== 16'd0 || lineStride !== 19'd0 ||
        startOffset !== 37'd0 || frameSize !== 37'd0) begin
      testsFailed++;
      $display("FAIL R11: reset state v=%0b c=%0b fmt=%0d sz=%0d, expected all zero",
               modeValid, modeChanged, pixFmt, frameSize);
    end
    @(negedge clk);
    rstN = 1'b1;
    apply(1, 32, 640, 480, 0, 0, 0, 0, "R3 R4 R5 R8 first 32-bit mode");
    apply(1, 32, 640, 480, 0, 0, 0, 0, "R9 identical mode");
    apply(1, 32, 640, 480, 0, 0, 0, 1, "R3 R8 byte order flip only");
    apply(1, 16, 640, 480, 1024, 8, 2, 0, "R3 R4 R5 16-bit with virtual width and pan");
    apply(1, 16, 1024, 480, 640, 0, 0, 0, "R4 virtual width below visible");
    apply(0, 32, 800, 600, 0, 0, 0, 0, "R1 R10 disabled");
    apply(1, 24, 800, 600, 0, 0, 0, 0, "R2 depth 24");
    apply(1, 8, 800, 600, 0, 0, 0, 0, "R2 depth 8");
    apply(1, 32, 63, 480, 0, 0, 0, 0, "R6 width 63");
    apply(1, 32, 640, 63, 0, 0, 0, 0, "R6 height 63");
    apply(1, 32, 64, 64, 0, 0, 0, 0, "R6 R8 exactly 64x64");
    apply(1, 32, 2048, 2048, 0, 0, 0, 0, "R7 frame ends at memory size");
    apply(1, 32, 2048, 2048, 0, 0, 1, 0, "R7 R10 one line past memory");
    apply(1, 32, 4096, 4096, 0, 0, 0, 1, "R7 R10 gross overrun with new geometry");
    apply(1, 32, 2048, 2048, 0, 0, 0, 0, "R9 return to held mode");
    apply(1, 32, 640, 480, 0, 100, 50, 0, "R5 R8 pan in 32-bit");
    @(negedge clk);
    @(negedge clk);
    driverDone = 1'b1;
  end

  initial begin
    fork
      wait (driverDone);
      begin
        #(CLK_PERIOD * 20000);
        testsFailed++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule